// File: doc/BRIEF.md
# Manchester Receive Deserializer with Squelch-Gated Bit-Clock Tracking

This block turns a 10 Mbps Manchester-coded receive line into 4-bit nibbles for a MAC-side nibble interface. The line is oversampled at eight samples per bit cell on the system clock. A squelch-valid input from the analog front end gates the whole receive path. While squelch is low, the bit-timing counter free-runs on the local bit period and line activity has no effect. When squelch rises, the tracker hunts for a line transition and takes it as its first phase reference. It then qualifies further transitions. The first mid-cell transition after lock gives a bit.

Each bit value comes straight from the direction of the mid-cell transition, so decoding happens inside recovery. Transitions on cell boundaries fall outside the acceptance window and are dropped. Every four decoded bits form one nibble, which is presented with a one-cycle strobe and a level data-valid. If a mid-cell transition is missing, or squelch falls, any partial nibble is thrown away, data-valid drops and the tracker starts hunting again.

Top module: `mrx_rx`

## Requirements
- R1: With ideal line timing, consecutive nibble strobes within one frame are exactly 32 clock cycles apart (four bit cells of eight samples each).
- R2: A low-to-high mid-cell transition decodes as 1 and a high-to-low one as 0. The first decoded bit of each nibble appears on rxd_o[0] and the fourth on rxd_o[3]. The number of nibbles delivered equals the number of whole groups of four bits decoded after lock.
- R3: While squelch is low, line activity produces no nibble strobe and rx_dv_o stays low.
- R4: After squelch rises, the first line transition sets the phase reference. Lock is declared on the fourth further transition that falls 7 to 9 samples after the previous one, i.e. on the fifth transition (fewer than 12). Decoding starts at the next mid-cell transition, so the first nibble strobe follows the ninth transition and comes before the tenth.
- R5: When squelch is valid from the first preamble bit, the first six delivered nibbles carry the preamble value 4'b1010 (line order 0,1,0,1).
- R6: A mid-cell transition is accepted 7 to 9 samples after the previous accepted one. Transitions outside that window, such as cell-boundary transitions, are ignored.
- R7: If no transition is accepted within 9 samples of the previous one while locked, code_err_o pulses for exactly one cycle. The partial nibble is discarded, rx_dv_o falls and the tracker unlocks.
- R8: When squelch falls, any partial nibble is discarded and rx_dv_o is low no later than three clock cycles after the squelch input falls.
- R9: rx_dv_o rises together with the first nibble strobe of a frame. nib_stb_o is never high while rx_dv_o is low. rxd_o holds its value between strobes.
- R10: The asynchronous active-low reset immediately clears rxd_o, rx_dv_o, nib_stb_o and code_err_o, along with lock state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, eight times the bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Oversampled Manchester receive line |
| squelch_i | input | 1 | Squelch reports valid line activity |
| rxd_o | output | 4 | Received nibble, first bit in bit 0 |
| rx_dv_o | output | 1 | Receive data valid |
| nib_stb_o | output | 1 | One-cycle strobe per delivered nibble |
| code_err_o | output | 1 | One-cycle pulse on a missing mid-cell transition |

## Verification
The failure modes differ in how soon they show at the ports:
- A wrong phase count or acceptance window breaks the strict 32-cycle strobe cadence within a single nibble. It also moves the first strobe off the ninth line transition.
- A wrong bit polarity or bit order corrupts the very first preamble nibble.
- A stale nibble index is exposed only at the end of a frame, where the delivered nibble count no longer matches the number of whole groups of four decoded bits.
- A tracker that fails to unlock on a missing transition or on a squelch drop leaves rx_dv_o high a few cycles too long, which the per-cycle comparison catches.

// File: rtl/mrx_pkg.sv
`timescale 1ns/1ps
package mrx_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_HUNT = 2'd1,
    TRK_ACQ  = 2'd2,
    TRK_LOCK = 2'd3
  } trk_st_e;
endpackage

// File: rtl/mrx_sync.sv
`timescale 1ns/1ps
module mrx_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[g] <= '0;
        else         pipe[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[g] <= '0;
        else         pipe[g] <= pipe[g-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/mrx_tracker.sv
`timescale 1ns/1ps
module mrx_tracker
  import mrx_pkg::*;
#(
  parameter int unsigned OSR        = 8,
  parameter int unsigned TOL        = 1,
  parameter int unsigned LOCK_EDGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic sq_i,
  output logic bit_vld_o,
  output logic bit_val_o,
  output logic flush_o,
  output logic code_err_o
);
  localparam int unsigned CNT_MAX = OSR + TOL + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned GOOD_W  = $clog2(LOCK_EDGES + 1);
  localparam logic [CNT_W-1:0]  WIN_LO   = CNT_W'(OSR - TOL);
  localparam logic [CNT_W-1:0]  WIN_HI   = CNT_W'(OSR + TOL);
  localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [GOOD_W-1:0] GOOD_FIN = GOOD_W'(LOCK_EDGES - 1);

  trk_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [GOOD_W-1:0] good;
  logic              line_q;
  logic              edge_w, in_win, miss;
  logic [CNT_W-1:0]  cnt_inc;

  assign edge_w  = line_i ^ line_q;
  assign in_win  = (cnt >= WIN_LO) && (cnt <= WIN_HI);
  assign cnt_inc = (cnt == CNT_SAT) ? cnt : cnt + 1'b1;
  // no qualifying mid-cell edge by the last in-window sample
  assign miss    = (st == TRK_LOCK) && sq_i && !(edge_w && in_win) && (cnt >= WIN_HI);

  assign bit_vld_o = (st == TRK_LOCK) && sq_i && edge_w && in_win;
  assign bit_val_o = line_i;  // level after the mid-cell edge is the bit
  assign flush_o   = !sq_i || miss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st         <= TRK_IDLE;
      cnt        <= '0;
      good       <= '0;
      line_q     <= 1'b0;
      code_err_o <= 1'b0;
    end else begin
      line_q     <= line_i;
      code_err_o <= miss;
      if (!sq_i) begin
        // local bit timing free-runs while squelched
        st   <= TRK_IDLE;
        good <= '0;
        cnt  <= (cnt >= CNT_LAST) ? '0 : cnt + 1'b1;
      end else begin
        unique case (st)
          TRK_IDLE: begin
            st   <= TRK_HUNT;
            cnt  <= '0;
            good <= '0;
          end
          TRK_HUNT: begin
            if (edge_w) begin
              st   <= TRK_ACQ;
              cnt  <= CNT_W'(1);
              good <= '0;
            end else begin
              cnt <= cnt_inc;
            end
          end
          TRK_ACQ: begin
            if (edge_w) begin
              cnt <= CNT_W'(1);
              if (in_win) begin
                if (good == GOOD_FIN) begin
                  st   <= TRK_LOCK;
                  good <= '0;
                end else begin
                  good <= good + GOOD_W'(1);
                end
              end else begin
                good <= '0;
              end
            end else begin
              cnt <= cnt_inc;
            end
          end
          TRK_LOCK: begin
            if (edge_w && in_win) begin
              cnt <= CNT_W'(1);
            end else if (miss) begin
              st   <= TRK_HUNT;
              cnt  <= '0;
              good <= '0;
            end else begin
              cnt <= cnt_inc;
            end
          end
          default: st <= TRK_IDLE;
        endcase
      end
    end
  end

  a_r7_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_err_o |=> !code_err_o);

  a_r7_err_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_err_o |-> (st != TRK_LOCK));
endmodule

// File: rtl/mrx_deser.sv
`timescale 1ns/1ps
module mrx_deser #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             bit_val_i,
  input  logic             flush_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             nib_stb_o,
  output logic             rx_dv_o
);
  localparam int unsigned      IDX_W    = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NIB_W - 1);

  logic [NIB_W-1:0] sh, nxt;
  logic [IDX_W-1:0] idx;

  always_comb begin
    nxt      = sh;
    nxt[idx] = bit_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh        <= '0;
      idx       <= '0;
      rxd_o     <= '0;
      nib_stb_o <= 1'b0;
      rx_dv_o   <= 1'b0;
    end else begin
      nib_stb_o <= 1'b0;
      if (flush_i) begin
        sh      <= '0;
        idx     <= '0;
        rx_dv_o <= 1'b0;
      end else if (bit_vld_i) begin
        if (idx == IDX_LAST) begin
          rxd_o     <= nxt;
          nib_stb_o <= 1'b1;
          rx_dv_o   <= 1'b1;
          idx       <= '0;
          sh        <= '0;
        end else begin
          sh  <= nxt;
          idx <= idx + 1'b1;
        end
      end
    end
  end

  a_r9_stb_with_dv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o |-> rx_dv_o);

  a_r1_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o |=> !nib_stb_o);
endmodule

// File: rtl/mrx_rx.sv
`timescale 1ns/1ps
module mrx_rx #(
  parameter int unsigned OSR         = 8,
  parameter int unsigned TOL         = 1,
  parameter int unsigned LOCK_EDGES  = 4,
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             squelch_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o,
  output logic             nib_stb_o,
  output logic             code_err_o
);
  logic line_s, sq_s;
  logic bit_vld, bit_val, flush;

  // line and squelch share one synchronizer so they stay aligned
  mrx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({squelch_i, line_i}),
    .q_o   ({sq_s, line_s})
  );

  mrx_tracker #(.OSR(OSR), .TOL(TOL), .LOCK_EDGES(LOCK_EDGES)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (line_s),
    .sq_i      (sq_s),
    .bit_vld_o (bit_vld),
    .bit_val_o (bit_val),
    .flush_o   (flush),
    .code_err_o(code_err_o)
  );

  mrx_deser #(.NIB_W(NIB_W)) u_des (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_vld_i(bit_vld),
    .bit_val_i(bit_val),
    .flush_i  (flush),
    .rxd_o    (rxd_o),
    .nib_stb_o(nib_stb_o),
    .rx_dv_o  (rx_dv_o)
  );

  a_r8_squelch_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sq_s |=> !rx_dv_o);

  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sq_s && $past(!sq_s)) |-> !nib_stb_o);
endmodule

// File: tb/sim_mrx_rx.sv
`timescale 1ns/1ps
module sim_mrx_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic       sq = 1'b0;
  logic [3:0] rxd;
  logic       rx_dv, stb, err;

  always #4 clk = ~clk;

  mrx_rx u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .line_i    (line),
    .squelch_i (sq),
    .rxd_o     (rxd),
    .rx_dv_o   (rx_dv),
    .nib_stb_o (stb),
    .code_err_o(err)
  );

  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;
  logic [3:0] exp_q[$];
  bit         fb[$];
  bit         ideal = 1'b1, expect_err = 1'b0, saw_err = 1'b0;
  int         sq_low = 0, edges = 0, nib_n = 0;
  longint     cyc = 0, last_stb = 0;
  logic       prev_line = 1'b0;
  logic [3:0] prev_rxd = 4'h0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_rxd = 4'h0;
      nib_n    = 0;
    end else begin
      if (!sq) begin
        sq_low++;
        edges = 0;
      end else begin
        sq_low = 0;
        if (line !== prev_line) edges++;
      end
      prev_line = line;
      if (!rx_dv) nib_n = 0;
      if (sq_low >= 5) chk(!rx_dv, "R8 rx_dv after squelch drop", rx_dv, 0);
      if (stb) begin
        chk(rx_dv, "R9 strobe without rx_dv", rx_dv, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected nibble", rxd, -1);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(rxd == e, "R2 nibble value", rxd, e);
        end
        if (nib_n < 6) chk(rxd == 4'b1010, "R5 preamble nibble", rxd, 4'b1010);
        if (nib_n == 0) chk(edges == 9, "R4 first strobe after ninth transition", edges, 9);
        if (nib_n > 0 && ideal) chk(cyc - last_stb == 32, "R1 strobe spacing", int'(cyc - last_stb), 32);
        last_stb = cyc;
        nib_n++;
      end else begin
        chk(rxd == prev_rxd, "R9 rxd hold", rxd, prev_rxd);
      end
      prev_rxd = rxd;
      if (err) begin
        if (expect_err) saw_err = 1'b1;
        else chk(1'b0, "R7 unexpected code error", 1, 0);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic add_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) fb.push_back(v[i]);
  endtask

  task automatic make_frame(input int nbytes, input int seed);
    fb.delete();
    for (int i = 0; i < 28; i++) begin
      fb.push_back(1'b1);
      fb.push_back(1'b0);
    end
    add_byte(8'hD5);  // 1,0,1,0,1,0,1,1 in line order
    for (int i = 0; i < nbytes; i++) add_byte(8'(seed * 29 + i * 73 + 13));
  endtask

  // sq_at: bit where squelch rises; k: bits sent; rst_at: bit where reset hits (-1 none)
  task automatic send(input int sq_at, input int k, input bit jit, input bit viol, input int rst_at);
    int st;
    st = sq_at + 5;
    for (int n = 0; n < (k - st) / 4; n++)
      exp_q.push_back({fb[st+4*n+3], fb[st+4*n+2], fb[st+4*n+1], fb[st+4*n]});
    expect_err = viol;
    saw_err    = 1'b0;
    ideal      = !jit;
    line       = 1'b0;
    sq         = (sq_at == 0);
    for (int b = 0; b < k; b++) begin
      int j;
      if (b == sq_at) sq = 1'b1;
      if (b == rst_at) begin
        rst_n = 1'b0;
        #1;
        chk(rxd == 4'h0 && !rx_dv && !stb && !err, "R10 async reset clears outputs",
            {rxd, rx_dv, stb, err}, 0);
        exp_q.delete();
        sq   = 1'b0;
        line = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (20) tick();
        return;
      end
      j = jit ? (b % 2) : 0;
      line = !fb[b];
      repeat (4 + j) tick();
      line = fb[b];
      repeat (4 - j) tick();
    end
    if (viol) begin
      repeat (24) tick();
      chk(!rx_dv, "R7 rx_dv low after missing transition", rx_dv, 0);
      chk(saw_err, "R7 code error reported", saw_err, 1);
    end else begin
      repeat (1) tick();
    end
    sq = 1'b0;
    repeat (12) tick();
    chk(exp_q.size() == 0, "R2 nibble count", exp_q.size(), 0);
    exp_q.delete();
    line = 1'b0;
    repeat (20) tick();
  endtask

  initial begin
    repeat (3) tick();
    chk(rxd == 4'h0 && !rx_dv && !stb && !err, "R10 reset state", {rxd, rx_dv, stb, err}, 0);
    rst_n = 1'b1;
    repeat (10) tick();

    // R1 R2 R4 R5: ideal frame, squelch from first bit
    make_frame(6, 1);
    send(0, fb.size(), 1'b0, 1'b0, -1);

    // R6: boundary edges from repeated data bits are ignored
    fb.delete();
    for (int i = 0; i < 28; i++) begin fb.push_back(1'b1); fb.push_back(1'b0); end
    add_byte(8'hD5); add_byte(8'h00); add_byte(8'hFF); add_byte(8'hA5); add_byte(8'h3C);
    send(0, fb.size(), 1'b0, 1'b0, -1);

    // R6: mid-cell edges jittered by one sample
    make_frame(6, 2);
    send(0, fb.size(), 1'b1, 1'b0, -1);

    // R4: squelch valid late in the preamble
    make_frame(6, 3);
    send(20, fb.size(), 1'b0, 1'b0, -1);

    // R7: missing mid-cell transition
    make_frame(6, 4);
    send(0, 84, 1'b0, 1'b1, -1);

    // R8: squelch drop mid-frame leaves a partial nibble
    make_frame(6, 5);
    send(0, 75, 1'b0, 1'b0, -1);

    // R3: line noise while squelch is low
    sq = 1'b0;
    for (int i = 0; i < 200; i++) begin
      line = ((i * 7 + i / 3) % 5) < 2;
      tick();
    end
    chk(!rx_dv && exp_q.size() == 0, "R3 idle keeps rx_dv low", rx_dv, 0);
    line = 1'b0;
    repeat (10) tick();

    // R10: reset in the middle of a frame
    make_frame(6, 6);
    send(0, fb.size(), 1'b0, 1'b0, 70);

    // R1 R2: a further ideal frame after reset recovery
    make_frame(4, 7);
    send(0, fb.size(), 1'b0, 1'b0, -1);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule